// File: doc/BRIEF.md
# Raster Timing and Colour-Bar Generator

This block produces the scan timing for a parallel RGB display from a single pixel clock. It also produces a fixed test image. Two counters run in the pixel clock domain:

- The horizontal counter steps on every clock.
- The vertical counter steps once per line.

Both counters walk through four segments in a fixed order: back porch, active, front porch, sync. The outputs are the sync strobes, a data-enable, the coordinates of the pixel inside the active window, and a 24-bit colour. The colour forms eight equal-width vertical bars.

The default geometry is 800x600, with a pixel clock of about 38.4 MHz giving a frame rate near 56 Hz:

| Axis | Back porch | Active | Front porch | Sync | Total |
|------|-----------|--------|-------------|------|-------|
| Horizontal (clocks) | 129 | 800 | 32 | 129 | 1090 |
| Vertical (lines) | 14 | 600 | 1 | 4 | 619 |

One frame is 674710 clocks. Every segment length is a parameter, so other geometries need only new parameter values. An 800x480 panel is one example.

The pixel stream leaves the block at a fixed rate, one pixel per clock. `de_o` acts as the valid qualifier for `rgb_o`, `x_o` and `y_o`. There is no ready input and no back-pressure: a display sink has to accept every pixel in the cycle it is presented. The outputs are combinational decodes of the two counter registers. They therefore change in the same cycle as the counters.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal counter starts at 0 and advances by one on every clock. It wraps after H_BACK+H_ACTIVE+H_FRONT+H_SYNC clocks (1090 by default). Its positions are ordered back porch, then active, then front porch, then sync. With defaults, positions 0..128 are back porch, 129..928 active, 929..960 front porch and 961..1089 sync.
- R2: The vertical counter holds the line number and wraps after V_BACK+V_ACTIVE+V_FRONT+V_SYNC lines (619 by default). Lines are ordered the same way as R1. With defaults, lines 0..13 are back porch, 14..613 active, 614 front porch and 615..618 sync.
- R3: The vertical counter changes only on the clock edge that ends the last position of a line.
- R4: `de_o` is 1 only when both counters are in their active segments.
- R5: `x_o` is the horizontal position minus H_BACK while the horizontal counter is active, and 0 otherwise. `y_o` is the line number minus V_BACK while the vertical counter is active, and 0 otherwise.
- R6: `rgb_o` is 0 whenever `de_o` is 0.
- R7: While `de_o` is 1, the bar index is i = x_o / (H_ACTIVE/8), clamped to 7. `rgb_o` is packed as {R[23:16], G[15:8], B[7:0]}. R is 8'hFF when bit 2 of i is 0, G is 8'hFF when bit 1 of i is 0, and B is 8'hFF when bit 0 of i is 0. Each channel is 8'h00 otherwise. Bar 0 is therefore white and bar 7 black.
- R8: `hsync_o` equals HSYNC_ACTIVE_HIGH during the horizontal sync segment and its complement at all other times. `vsync_o` behaves the same way with VSYNC_ACTIVE_HIGH during the vertical sync lines. Both parameters default to 1.
- R9: While `rst` is 1 at a rising clock edge, both counters return to position 0. That is the first back-porch clock of the first back-porch line.
- R10: A geometry other than the default, with any segment lengths and sync polarities, works by changing parameters only. R1 to R8 then hold for that geometry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_o | output | 1 | Horizontal sync, polarity from HSYNC_ACTIVE_HIGH |
| vsync_o | output | 1 | Vertical sync, polarity from VSYNC_ACTIVE_HIGH |
| de_o | output | 1 | Data enable (valid for the pixel outputs) |
| x_o | output | XW ($clog2(H_ACTIVE), 10 by default) | Active-window column |
| y_o | output | YW ($clog2(V_ACTIVE), 10 by default) | Active-window row |
| rgb_o | output | 24 | Pixel colour {R,G,B} |

## Verification
The default instance is probed at selected clocks:

- Each segment boundary of the first lines, which separates back porch from active, active from front porch and front porch from sync.
- The first active lines, where each bar edge is sampled one pixel either side. This distinguishes an off-by-one in the bar divider from a wrong colour mapping.
- Columns in the active range while the line is still in vertical blanking. These show that data-enable and colour need both axes to be active.

A second instance uses a small geometry with an active-low horizontal sync. It is compared on every clock over two full frames against a model built from the requirements. This covers the vertical order, the line-end advance, frame wrap and the polarity parameter. A reset applied in mid-line confirms the return to the first back-porch position.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [1:0] {
    SEG_BACK   = 2'd0,
    SEG_ACTIVE = 2'd1,
    SEG_FRONT  = 2'd2,
    SEG_SYNC   = 2'd3
  } seg_e;

  localparam int CHAN_W = 8;
  localparam int NUM_CHAN = 3;
  localparam int NUM_BARS = 8;
  localparam int BAR_IDX_W = $clog2(NUM_BARS);
endpackage

// File: rtl/seg_counter.sv
module seg_counter
  import raster_pkg::*;
#(
  parameter int BP   = 129,
  parameter int ACT  = 800,
  parameter int FP   = 32,
  parameter int SW   = 129,
  parameter int CW   = $clog2(BP + ACT + FP + SW),
  parameter int PW   = $clog2(ACT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  output logic [CW-1:0] cnt_o,
  output seg_e          seg_o,
  output logic          last_o,
  output logic [PW-1:0] pos_o
);
  localparam int TOTAL   = BP + ACT + FP + SW;
  localparam int ACT_END = BP + ACT;
  localparam int FP_END  = ACT_END + FP;

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (int'(cnt_q) < BP) begin
      seg_o = SEG_BACK;
    end else if (int'(cnt_q) < ACT_END) begin
      seg_o = SEG_ACTIVE;
    end else if (int'(cnt_q) < FP_END) begin
      seg_o = SEG_FRONT;
    end else begin
      seg_o = SEG_SYNC;
    end
  end

  assign pos_o = (seg_o == SEG_ACTIVE) ? PW'(int'(cnt_q) - BP) : '0;
  assign cnt_o = cnt_q;

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && last_o) |=> (cnt_q == '0));

  // R1
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(cnt_q));
endmodule

// File: rtl/bar_pattern.sv
module bar_pattern
  import raster_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int XW       = $clog2(H_ACTIVE)
) (
  input  logic [XW-1:0]                x_i,
  input  logic                         de_i,
  output logic [NUM_CHAN*CHAN_W-1:0]   rgb_o
);
  localparam int BAR_W = (H_ACTIVE / NUM_BARS > 0) ? H_ACTIVE / NUM_BARS : 1;

  logic [BAR_IDX_W-1:0] idx;

  always_comb begin
    int q;
    q = int'(x_i) / BAR_W;
    idx = (q > NUM_BARS - 1) ? BAR_IDX_W'(NUM_BARS - 1) : BAR_IDX_W'(q);
  end

  // channel c (0 = blue, 1 = green, 2 = red) is lit when index bit c is clear
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    assign rgb_o[c*CHAN_W +: CHAN_W] = {CHAN_W{de_i & ~idx[c]}};
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int H_BACK   = 129,
  parameter int H_ACTIVE = 800,
  parameter int H_FRONT  = 32,
  parameter int H_SYNC   = 129,
  parameter int V_BACK   = 14,
  parameter int V_ACTIVE = 600,
  parameter int V_FRONT  = 1,
  parameter int V_SYNC   = 4,
  parameter bit HSYNC_ACTIVE_HIGH = 1'b1,
  parameter bit VSYNC_ACTIVE_HIGH = 1'b1,
  parameter int XW = $clog2(H_ACTIVE),
  parameter int YW = $clog2(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic [23:0]   rgb_o
);
  localparam int H_TOTAL = H_BACK + H_ACTIVE + H_FRONT + H_SYNC;
  localparam int V_TOTAL = V_BACK + V_ACTIVE + V_FRONT + V_SYNC;
  localparam int HCW = $clog2(H_TOTAL);
  localparam int VCW = $clog2(V_TOTAL);

  logic [HCW-1:0] h_cnt;
  logic [VCW-1:0] v_cnt;
  seg_e           h_seg, v_seg;
  logic           h_last, v_last;
  logic           h_sync_raw, v_sync_raw;

  seg_counter #(
    .BP(H_BACK), .ACT(H_ACTIVE), .FP(H_FRONT), .SW(H_SYNC),
    .CW(HCW), .PW(XW)
  ) u_hcnt (
    .clk(clk), .rst(rst), .adv_i(1'b1),
    .cnt_o(h_cnt), .seg_o(h_seg), .last_o(h_last), .pos_o(x_o)
  );

  seg_counter #(
    .BP(V_BACK), .ACT(V_ACTIVE), .FP(V_FRONT), .SW(V_SYNC),
    .CW(VCW), .PW(YW)
  ) u_vcnt (
    .clk(clk), .rst(rst), .adv_i(h_last),
    .cnt_o(v_cnt), .seg_o(v_seg), .last_o(v_last), .pos_o(y_o)
  );

  assign de_o       = (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);
  assign h_sync_raw = (h_seg == SEG_SYNC);
  assign v_sync_raw = (v_seg == SEG_SYNC);

  if (HSYNC_ACTIVE_HIGH) begin : g_hs_hi
    assign hsync_o = h_sync_raw;
  end else begin : g_hs_lo
    assign hsync_o = ~h_sync_raw;
  end

  if (VSYNC_ACTIVE_HIGH) begin : g_vs_hi
    assign vsync_o = v_sync_raw;
  end else begin : g_vs_lo
    assign vsync_o = ~v_sync_raw;
  end

  bar_pattern #(.H_ACTIVE(H_ACTIVE), .XW(XW)) u_bars (
    .x_i(x_o), .de_i(de_o), .rgb_o(rgb_o)
  );

  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    (h_last && v_last) |=> (h_cnt == '0 && v_cnt == '0));

  // R3
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !h_last |=> $stable(v_cnt));

  // R4
  de_window_chk: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (int'(x_o) < H_ACTIVE && int'(y_o) < V_ACTIVE));

  // R6
  blank_rgb_chk: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (rgb_o == '0));

  // R8
  sync_vs_de_chk: assert property (@(posedge clk) disable iff (rst)
    (hsync_o == HSYNC_ACTIVE_HIGH || vsync_o == VSYNC_ACTIVE_HIGH) |-> !de_o);
endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  // small geometry for the second instance
  localparam int SHB = 3, SHA = 16, SHF = 2, SHS = 3;
  localparam int SVB = 2, SVA = 4, SVF = 1, SVS = 2;
  localparam int SHT = SHB + SHA + SHF + SHS;
  localparam int SVT = SVB + SVA + SVF + SVS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   ncyc;
  int   nchk = 0;
  int   nfail = 0;

  logic        hs0, vs0, de0;
  logic [9:0]  x0, y0;
  logic [23:0] rgb0;
  logic        hs1, vs1, de1;
  logic [3:0]  x1;
  logic [1:0]  y1;
  logic [23:0] rgb1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) ncyc <= 0;
    else     ncyc <= ncyc + 1;
  end

  raster_timing_gen u0 (
    .clk(clk), .rst(rst), .hsync_o(hs0), .vsync_o(vs0), .de_o(de0),
    .x_o(x0), .y_o(y0), .rgb_o(rgb0)
  );

  raster_timing_gen #(
    .H_BACK(SHB), .H_ACTIVE(SHA), .H_FRONT(SHF), .H_SYNC(SHS),
    .V_BACK(SVB), .V_ACTIVE(SVA), .V_FRONT(SVF), .V_SYNC(SVS),
    .HSYNC_ACTIVE_HIGH(1'b0), .VSYNC_ACTIVE_HIGH(1'b1)
  ) u_small (
    .clk(clk), .rst(rst), .hsync_o(hs1), .vsync_o(vs1), .de_o(de1),
    .x_o(x1), .y_o(y1), .rgb_o(rgb1)
  );

  typedef struct packed {
    int          n;
    logic        hs;
    logic        vs;
    logic        de;
    logic [9:0]  x;
    logic [9:0]  y;
    logic [23:0] rgb;
  } vec_t;

  localparam int NVEC = 21;
  // cycles counted from reset release on the default 800x600 instance
  localparam vec_t VEC [NVEC] = '{
    '{0,     1'b0, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{128,   1'b0, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{129,   1'b0, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{229,   1'b0, 1'b0, 1'b0, 10'd100, 10'd0, 24'h000000},
    '{960,   1'b0, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{961,   1'b1, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{1089,  1'b1, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{1090,  1'b0, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{15259, 1'b1, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{15260, 1'b0, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{15389, 1'b0, 1'b0, 1'b1, 10'd0,   10'd0, 24'hFFFFFF},
    '{15488, 1'b0, 1'b0, 1'b1, 10'd99,  10'd0, 24'hFFFFFF},
    '{15489, 1'b0, 1'b0, 1'b1, 10'd100, 10'd0, 24'hFFFF00},
    '{15689, 1'b0, 1'b0, 1'b1, 10'd300, 10'd0, 24'hFF0000},
    '{15788, 1'b0, 1'b0, 1'b1, 10'd399, 10'd0, 24'hFF0000},
    '{15789, 1'b0, 1'b0, 1'b1, 10'd400, 10'd0, 24'h00FFFF},
    '{15889, 1'b0, 1'b0, 1'b1, 10'd500, 10'd0, 24'h00FF00},
    '{16188, 1'b0, 1'b0, 1'b1, 10'd799, 10'd0, 24'h000000},
    '{16189, 1'b0, 1'b0, 1'b0, 10'd0,   10'd0, 24'h000000},
    '{16479, 1'b0, 1'b0, 1'b1, 10'd0,   10'd1, 24'hFFFFFF},
    '{16480, 1'b0, 1'b0, 1'b1, 10'd1,   10'd1, 24'hFFFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s n=%0d actual=%0h expected=%0h", req, ncyc, act, exp);
    end
  endtask

  function automatic logic [23:0] bar_rgb(input int x, input int bw);
    int i;
    i = x / bw;
    if (i > 7) i = 7;
    bar_rgb = {{8{i[2] == 1'b0}}, {8{i[1] == 1'b0}}, {8{i[0] == 1'b0}}};
  endfunction

  task automatic wait_to(input int target);
    while (ncyc < target) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: state during reset is the first back-porch position
    chk("R9 hsync in reset", 32'(hs0), 32'd0);
    chk("R9 de in reset", 32'(de0), 32'd0);
    rst = 1'b0;

    // table walk: R1 R2 R4 R5 R6 R7 on the default geometry
    for (int k = 0; k < NVEC; k++) begin
      wait_to(VEC[k].n);
      chk("R1/R8 hsync", 32'(hs0), 32'(VEC[k].hs));
      chk("R2 vsync", 32'(vs0), 32'(VEC[k].vs));
      chk("R4 de", 32'(de0), 32'(VEC[k].de));
      chk("R5 x", 32'(x0), 32'(VEC[k].x));
      chk("R5 y", 32'(y0), 32'(VEC[k].y));
      chk("R6/R7 rgb", 32'(rgb0), 32'(VEC[k].rgb));
    end

    // R9: reset in mid-line and mid-frame
    wait_to(16500);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 x after reset", 32'(x0), 32'd0);
    chk("R9 de after reset", 32'(de0), 32'd0);
    chk("R9 small hsync inactive-high after reset", 32'(hs1), 32'd1);
    rst = 1'b0;
    wait_to(129);
    chk("R9 x at first active column", 32'(x0), 32'd0);
    chk("R9 de still blank on line 0", 32'(de0), 32'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;

    // R10 R3 R8: small geometry, every clock over two frames plus a little
    for (int n = 0; n < 2 * SHT * SVT + 20; n++) begin
      int h, v;
      logic hact, vact, ede;
      wait_to(n);
      h = n % SHT;
      v = (n / SHT) % SVT;
      hact = (h >= SHB) && (h < SHB + SHA);
      vact = (v >= SVB) && (v < SVB + SVA);
      ede  = hact && vact;
      chk("R10 R8 active-low hsync", 32'(hs1), 32'(!(h >= SHB + SHA + SHF)));
      chk("R10 R2 R3 vsync", 32'(vs1), 32'(v >= SVB + SVA + SVF));
      chk("R10 R4 de", 32'(de1), 32'(ede));
      chk("R10 R5 x", 32'(x1), hact ? 32'(h - SHB) : 32'd0);
      chk("R10 R5 y", 32'(y1), vact ? 32'(v - SVB) : 32'd0);
      chk("R10 R7 rgb", 32'(rgb1), ede ? 32'(bar_rgb(h - SHB, SHA / 8)) : 32'd0);
    end

    finish_run();
  end
endmodule